// File: doc/BRIEF.md
# Byte-to-Word Register Access Bridge

This block sits between a byte-oriented serial target front end and a core whose registers are 16 bits wide. The front end has already matched the device address and delivers one-byte transfers. Each transfer is a write or a read strobe, together with an 8-bit byte address and, for writes, an 8-bit data byte. There is no separate select line for command versus parameter, so the byte address alone decides what a transfer means.

The bridge turns these byte transfers into word-wide actions toward the core. Each word register appears as an even/odd byte address pair, and a word write is committed only when the pair arrives in upper-then-lower order. Parameterless commands are fired by writing zero to a command address. A shared pixel port packs or unpacks 16-bit pixels across alternating bytes. A fixed byte pair returns the status word.

Top module: `byte_word_bridge`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `reg_wr`, `cmd_stb`, `pix_push`, `pix_pull` and `rd_valid` are low and `rd_data` is zero. No pending byte survives reset, and the pixel phase restarts at the upper byte.
- R2: A write to byte address 2N (N below `CMD_BASE`) followed by a write to 2N+1 makes `reg_wr` pulse one cycle after the second write. `reg_waddr` is N and `reg_wdata` is {first byte, second byte}.
- R3: A write to an odd register address commits nothing unless the most recent pending upper byte belongs to the same word. A new upper byte to a different word replaces the pending one. Every lower-byte write clears the pending byte.
- R4: Writing 0x00 to the even byte address 2C of a command word C (`CMD_BASE` <= C < port word) makes `cmd_stb` pulse one cycle later with `cmd_code` = C. A nonzero byte, or a write to the odd address 2C+1, issues nothing.
- R5: A read of byte 2N+k places word N on `reg_raddr` in the same cycle. One cycle later `rd_valid` pulses, with `rd_data` equal to the upper byte of `reg_rdata` for k=0 and the lower byte for k=1. Reads may come in any order or singly.
- R6: A read of 0xFE returns `status_word[15:8]` and a read of 0xFF returns `status_word[7:0]`, in any order or singly, with the same one-cycle latency.
- R7: After the image-write command (word `CMD_IMG_WR`), successive writes to port 0xFD alternate upper and lower. Each lower write pulses `pix_push` one cycle later, with `pix_wdata` = {upper, lower}.
- R8: After the image-read command (word `CMD_IMG_RD`), a read of 0xFD in the upper phase returns `pix_rdata[15:8]` and latches all 16 bits. The next read of 0xFD returns the latched lower byte, even if `pix_rdata` has changed since, and pulses `pix_pull` in the same cycle as its `rd_valid`.
- R9: Issuing the image-write or the image-read command resets the port phase to upper. A half-written pixel is then dropped.
- R10: With no image command since reset, writes to 0xFD push nothing, and reads of 0xFD return 0x00 and pull nothing.
- R11: Every output strobe is a single-cycle pulse. At most one of `reg_wr`, `cmd_stb` and `pix_push` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Byte write strobe from the front end |
| rd_stb | input | 1 | Byte read strobe from the front end |
| byte_addr | input | ADDR_W | Byte address of the transfer |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data valid pulse |
| reg_raddr | output | ADDR_W-1 | Word address offered to the register file for reads |
| reg_rdata | input | 16 | Word read back from the register file |
| reg_wr | output | 1 | Word write pulse |
| reg_waddr | output | ADDR_W-1 | Word write address |
| reg_wdata | output | 16 | Word write data |
| cmd_stb | output | 1 | Command issue pulse |
| cmd_code | output | ADDR_W-1 | Word address of the issued command |
| pix_push | output | 1 | Pixel push pulse toward the core |
| pix_wdata | output | 16 | Pushed pixel |
| pix_pull | output | 1 | Request for the next readback pixel |
| pix_rdata | input | 16 | Current readback pixel from the core |
| status_word | input | 16 | Core status word |

## Verification
Every result of this bridge is registered once. A word commit, command pulse, pixel push or pull, and read byte all become visible right after the rising edge that captures the completing strobe. The bench drives each strobe on a falling edge for one clock period. A monitor samples on the next falling edge, which is half a period after the result edge, and pops the expected item from a queue in a fixed order. Any strobe seen with no matching expectation is reported against the requirement under test. After each negative case the bench idles a few cycles and checks that the queue is drained.

// File: rtl/bw_pkg.sv
package bw_pkg;

   typedef enum logic [2:0] {
      ACC_NONE = 3'd0,
      ACC_REG  = 3'd1,
      ACC_CMD  = 3'd2,
      ACC_PIX  = 3'd3,
      ACC_STAT = 3'd4
   } acc_e;

   typedef enum logic [1:0] {
      IMG_IDLE = 2'd0,
      IMG_WR   = 2'd1,
      IMG_RD   = 2'd2
   } img_mode_e;

   localparam int BYTE_W = 8;
   localparam int WORD_W = 2 * BYTE_W;

endpackage

// File: rtl/bw_decode.sv
module bw_decode
   import bw_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int CMD_BASE = 7'h40,
   parameter int PORT_WD  = 7'h7E,
   parameter int STAT_WD  = 7'h7F
) (
   input  logic [ADDR_W-1:0] byte_addr,
   output acc_e              kind,
   output logic              is_low,
   output logic [ADDR_W-2:0] waddr
);
   localparam int WA_W = ADDR_W - 1;
   localparam logic [WA_W-1:0] CMD_LO = WA_W'(CMD_BASE);
   localparam logic [WA_W-1:0] PORT_W = WA_W'(PORT_WD);
   localparam logic [WA_W-1:0] STAT_W = WA_W'(STAT_WD);

   assign waddr  = byte_addr[ADDR_W-1:1];
   assign is_low = byte_addr[0];

   always_comb begin
      if (waddr == STAT_W)
         kind = ACC_STAT;
      else if (waddr == PORT_W)
         kind = is_low ? ACC_PIX : ACC_NONE;
      else if (waddr < CMD_LO)
         kind = ACC_REG;
      else if (waddr < PORT_W)
         kind = ACC_CMD;
      else
         kind = ACC_NONE;
   end
endmodule

// File: rtl/bw_word_pair.sv
module bw_word_pair #(
   parameter int WA_W = 7,
   parameter int B_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_hit,
   input  logic              is_low,
   input  logic [WA_W-1:0]   waddr,
   input  logic [B_W-1:0]    wr_data,
   output logic              reg_wr,
   output logic [WA_W-1:0]   reg_waddr,
   output logic [2*B_W-1:0]  reg_wdata
);
   logic            pend_v;
   logic [WA_W-1:0] pend_a;
   logic [B_W-1:0]  pend_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_v    <= 1'b0;
         pend_a    <= '0;
         pend_d    <= '0;
         reg_wr    <= 1'b0;
         reg_waddr <= '0;
         reg_wdata <= '0;
      end else begin
         reg_wr <= 1'b0;
         if (wr_hit) begin
            if (!is_low) begin
               pend_v <= 1'b1;
               pend_a <= waddr;
               pend_d <= wr_data;
            end else begin
               pend_v <= 1'b0;
               if (pend_v && (pend_a == waddr)) begin
                  reg_wr    <= 1'b1;
                  reg_waddr <= waddr;
                  reg_wdata <= {pend_d, wr_data};
               end
            end
         end
      end
   end
endmodule

// File: rtl/bw_cmd_issue.sv
module bw_cmd_issue #(
   parameter int WA_W = 7,
   parameter int B_W  = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_hit,
   input  logic            is_low,
   input  logic [WA_W-1:0] waddr,
   input  logic [B_W-1:0]  wr_data,
   output logic            fire,
   output logic            cmd_stb,
   output logic [WA_W-1:0] cmd_code
);
   assign fire = wr_hit && !is_low && (wr_data == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_stb  <= 1'b0;
         cmd_code <= '0;
      end else begin
         cmd_stb <= fire;
         if (fire) cmd_code <= waddr;
      end
   end
endmodule

// File: rtl/bw_pix_port.sv
module bw_pix_port
   import bw_pkg::*;
#(
   parameter int WA_W      = 7,
   parameter int B_W       = 8,
   parameter int CMD_IMG_WR = 7'h41,
   parameter int CMD_IMG_RD = 7'h42
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_fire,
   input  logic [WA_W-1:0]  cmd_word,
   input  logic             wr_hit,
   input  logic             rd_hit,
   input  logic [B_W-1:0]   wr_data,
   input  logic [2*B_W-1:0] pix_rdata,
   output logic [B_W-1:0]   rd_byte,
   output logic             pix_push,
   output logic [2*B_W-1:0] pix_wdata,
   output logic             pix_pull
);
   localparam logic [WA_W-1:0] IW = WA_W'(CMD_IMG_WR);
   localparam logic [WA_W-1:0] IR = WA_W'(CMD_IMG_RD);

   img_mode_e        mode;
   logic             phase;
   logic [B_W-1:0]   hold;
   logic [2*B_W-1:0] latch;

   always_comb begin
      if (mode != IMG_RD)
         rd_byte = '0;
      else if (phase)
         rd_byte = latch[B_W-1:0];
      else
         rd_byte = pix_rdata[2*B_W-1:B_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode      <= IMG_IDLE;
         phase     <= 1'b0;
         hold      <= '0;
         latch     <= '0;
         pix_push  <= 1'b0;
         pix_pull  <= 1'b0;
         pix_wdata <= '0;
      end else begin
         pix_push <= 1'b0;
         pix_pull <= 1'b0;
         if (cmd_fire) begin
            if (cmd_word == IW) begin
               mode  <= IMG_WR;
               phase <= 1'b0;
            end else if (cmd_word == IR) begin
               mode  <= IMG_RD;
               phase <= 1'b0;
            end
         end else if (wr_hit && mode == IMG_WR) begin
            if (!phase) begin
               hold  <= wr_data;
               phase <= 1'b1;
            end else begin
               pix_push  <= 1'b1;
               pix_wdata <= {hold, wr_data};
               phase     <= 1'b0;
            end
         end else if (rd_hit && mode == IMG_RD) begin
            if (!phase) begin
               latch <= pix_rdata;
               phase <= 1'b1;
            end else begin
               pix_pull <= 1'b1;
               phase    <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/bw_read_mux.sv
module bw_read_mux
   import bw_pkg::*;
#(
   parameter int B_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rd_stb,
   input  acc_e             kind,
   input  logic             is_low,
   input  logic [2*B_W-1:0] reg_rdata,
   input  logic [2*B_W-1:0] status_word,
   input  logic [B_W-1:0]   pix_byte,
   output logic             rd_valid,
   output logic [B_W-1:0]   rd_data
);
   logic [2*B_W-1:0] word_sel;
   logic [B_W-1:0]   byte_sel;

   always_comb begin
      case (kind)
         ACC_REG:  word_sel = reg_rdata;
         ACC_STAT: word_sel = status_word;
         default:  word_sel = '0;
      endcase
      if (kind == ACC_PIX)
         byte_sel = pix_byte;
      else
         byte_sel = is_low ? word_sel[B_W-1:0] : word_sel[2*B_W-1:B_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_stb;
         if (rd_stb) rd_data <= byte_sel;
      end
   end
endmodule

// File: rtl/byte_word_bridge.sv
module byte_word_bridge
   import bw_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int CMD_BASE   = 7'h40,
   parameter int CMD_IMG_WR = 7'h41,
   parameter int CMD_IMG_RD = 7'h42
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stb,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] byte_addr,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic [ADDR_W-2:0] reg_raddr,
   input  logic [15:0]       reg_rdata,
   output logic              reg_wr,
   output logic [ADDR_W-2:0] reg_waddr,
   output logic [15:0]       reg_wdata,
   output logic              cmd_stb,
   output logic [ADDR_W-2:0] cmd_code,
   output logic              pix_push,
   output logic [15:0]       pix_wdata,
   output logic              pix_pull,
   input  logic [15:0]       pix_rdata,
   input  logic [15:0]       status_word
);
   localparam int WA_W    = ADDR_W - 1;
   localparam int TOP_WD  = (1 << WA_W) - 1;
   localparam int STAT_WD = TOP_WD;
   localparam int PORT_WD = TOP_WD - 1;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W too small");
   end
   if (CMD_BASE < 1 || CMD_BASE >= PORT_WD) begin : g_bad_base
      $error("CMD_BASE outside register space");
   end
   if (CMD_IMG_WR < CMD_BASE || CMD_IMG_WR >= PORT_WD ||
       CMD_IMG_RD < CMD_BASE || CMD_IMG_RD >= PORT_WD ||
       CMD_IMG_WR == CMD_IMG_RD) begin : g_bad_img
      $error("image command words must be distinct command words");
   end

   acc_e            kind;
   logic            is_low;
   logic [WA_W-1:0] waddr;
   logic            fire;
   logic [7:0]      pix_byte;

   bw_decode #(
      .ADDR_W(ADDR_W), .CMD_BASE(CMD_BASE),
      .PORT_WD(PORT_WD), .STAT_WD(STAT_WD)
   ) u_dec (
      .byte_addr(byte_addr), .kind(kind), .is_low(is_low), .waddr(waddr)
   );

   assign reg_raddr = waddr;

   bw_word_pair #(.WA_W(WA_W), .B_W(BYTE_W)) u_pair (
      .clk(clk), .rst(rst),
      .wr_hit(wr_stb && kind == ACC_REG), .is_low(is_low),
      .waddr(waddr), .wr_data(wr_data),
      .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata)
   );

   bw_cmd_issue #(.WA_W(WA_W), .B_W(BYTE_W)) u_cmd (
      .clk(clk), .rst(rst),
      .wr_hit(wr_stb && kind == ACC_CMD), .is_low(is_low),
      .waddr(waddr), .wr_data(wr_data),
      .fire(fire), .cmd_stb(cmd_stb), .cmd_code(cmd_code)
   );

   bw_pix_port #(
      .WA_W(WA_W), .B_W(BYTE_W),
      .CMD_IMG_WR(CMD_IMG_WR), .CMD_IMG_RD(CMD_IMG_RD)
   ) u_pix (
      .clk(clk), .rst(rst),
      .cmd_fire(fire), .cmd_word(waddr),
      .wr_hit(wr_stb && kind == ACC_PIX),
      .rd_hit(rd_stb && kind == ACC_PIX),
      .wr_data(wr_data), .pix_rdata(pix_rdata),
      .rd_byte(pix_byte),
      .pix_push(pix_push), .pix_wdata(pix_wdata), .pix_pull(pix_pull)
   );

   bw_read_mux #(.B_W(BYTE_W)) u_rd (
      .clk(clk), .rst(rst), .rd_stb(rd_stb),
      .kind(kind), .is_low(is_low),
      .reg_rdata(reg_rdata), .status_word(status_word), .pix_byte(pix_byte),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );
endmodule

// File: rtl/bw_bridge_chk.sv
module bw_bridge_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_stb,
   input logic              rd_stb,
   input logic [ADDR_W-1:0] byte_addr,
   input logic [7:0]        wr_data,
   input logic [7:0]        rd_data,
   input logic              rd_valid,
   input logic              reg_wr,
   input logic [ADDR_W-2:0] reg_waddr,
   input logic [15:0]       reg_wdata,
   input logic              cmd_stb,
   input logic              pix_push,
   input logic              pix_pull,
   input logic [15:0]       status_word
);
   localparam logic [ADDR_W-1:0] PORT_B = {{(ADDR_W-2){1'b1}}, 2'b01};
   localparam logic [ADDR_W-1:0] STAT_B = {{(ADDR_W-1){1'b1}}, 1'b0};

   logic past_rst;
   always_ff @(posedge clk) past_rst <= rst;

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      past_rst |-> !reg_wr && !cmd_stb && !pix_push && !pix_pull && !rd_valid);

   p_commit_src_r2: assert property (@(posedge clk) disable iff (rst)
      reg_wr |-> $past(wr_stb) && $past(byte_addr[0])
                 && reg_waddr == $past(byte_addr[ADDR_W-1:1])
                 && reg_wdata[7:0] == $past(wr_data));

   p_cmd_zero_r4: assert property (@(posedge clk) disable iff (rst)
      cmd_stb |-> $past(wr_stb) && $past(wr_data) == 8'h00 && !$past(byte_addr[0]));

   p_rd_latency_r5: assert property (@(posedge clk) disable iff (rst)
      $past(rd_stb) |-> rd_valid);

   p_stat_hi_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_valid && $past(byte_addr) == STAT_B) |-> rd_data == $past(status_word[15:8]));

   p_push_src_r7: assert property (@(posedge clk) disable iff (rst)
      pix_push |-> $past(wr_stb) && $past(byte_addr) == PORT_B);

   p_pull_src_r8: assert property (@(posedge clk) disable iff (rst)
      pix_pull |-> $past(rd_stb) && $past(byte_addr) == PORT_B && rd_valid);

   p_one_write_r11: assert property (@(posedge clk) disable iff (rst)
      $onehot0({reg_wr, cmd_stb, pix_push}));
endmodule

bind byte_word_bridge bw_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb),
   .byte_addr(byte_addr), .wr_data(wr_data), .rd_data(rd_data),
   .rd_valid(rd_valid), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
   .reg_wdata(reg_wdata), .cmd_stb(cmd_stb), .pix_push(pix_push),
   .pix_pull(pix_pull), .status_word(status_word)
);

// File: tb/byte_word_bridge_test.sv
module byte_word_bridge_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_stb = 1'b0, rd_stb = 1'b0;
   logic [7:0]  byte_addr = '0, wr_data = '0;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic [6:0]  reg_raddr, reg_waddr, cmd_code;
   logic [15:0] reg_rdata, reg_wdata, pix_wdata, pix_rdata;
   logic        reg_wr, cmd_stb, pix_push, pix_pull;
   logic [15:0] status_word = 16'hBEEF;
   logic [15:0] glitch = '0;
   int          pix_idx = 0;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   typedef struct {
      int    kind;
      int    addr;
      int    data;
      string tag;
   } item_t;
   item_t q[$];

   always #10 clk = ~clk;

   function automatic logic [15:0] model(input logic [6:0] n);
      return {1'b0, n, {1'b0, n} ^ 8'h5A};
   endfunction

   assign reg_rdata = model(reg_raddr);
   assign pix_rdata = {8'h30 + 8'(pix_idx), 8'h90 + 8'(pix_idx)} ^ glitch;

   always @(posedge clk) if (!rst && pix_pull) pix_idx <= pix_idx + 1;

   byte_word_bridge uut (
      .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .byte_addr(byte_addr), .wr_data(wr_data), .rd_data(rd_data),
      .rd_valid(rd_valid), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
      .cmd_stb(cmd_stb), .cmd_code(cmd_code), .pix_push(pix_push),
      .pix_wdata(pix_wdata), .pix_pull(pix_pull), .pix_rdata(pix_rdata),
      .status_word(status_word)
   );

   task automatic expect_item(input int k, input int a, input int d, input string t);
      item_t it;
      it.kind = k; it.addr = a; it.data = d; it.tag = t;
      q.push_back(it);
   endtask

   task automatic see(input int k, input int a, input int d);
      item_t e;
      checks++;
      if (q.size() == 0) begin
         errors++;
         $display("FAIL %s unexpected event: actual kind %0d addr %h data %h, expected none",
                  cur_req, k, a, d);
      end else begin
         e = q.pop_front();
         if (e.kind != k || e.addr != a || e.data != d) begin
            errors++;
            $display("FAIL %s actual kind %0d addr %h data %h, expected kind %0d addr %h data %h",
                     e.tag, k, a, d, e.kind, e.addr, e.data);
         end
      end
   endtask

   // monitor: kinds 0 commit, 1 command, 2 push, 3 pull, 4 read
   always @(negedge clk) begin
      if (!rst) begin
         if (reg_wr)   see(0, int'(reg_waddr), int'(reg_wdata));
         if (cmd_stb)  see(1, int'(cmd_code), 0);
         if (pix_push) see(2, 0, int'(pix_wdata));
         if (pix_pull) see(3, 0, 0);
         if (rd_valid) see(4, 0, int'(rd_data));
      end
   end

   task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_stb = 1'b1; byte_addr = a; wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a);
      @(negedge clk);
      rd_stb = 1'b1; byte_addr = a;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic drained(input string t);
      repeat (3) @(negedge clk);
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL %s actual %0d items pending, expected 0", t, q.size());
         q.delete();
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL all: watchdog actual running, expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: quiet outputs after reset
      checks++;
      if (reg_wr || cmd_stb || pix_push || pix_pull || rd_valid || rd_data != 8'h00) begin
         errors++;
         $display("FAIL R1 actual strobes %b%b%b%b%b rd %h, expected 00000 rd 00",
                  reg_wr, cmd_stb, pix_push, pix_pull, rd_valid, rd_data);
      end

      // R2: ordered pairs commit
      cur_req = "R2";
      bus_wr(8'h10, 8'hAB);
      expect_item(0, 'h08, 'hABCD, "R2");
      bus_wr(8'h11, 8'hCD);
      @(negedge clk);
      checks++;   // R11: commit pulse lasts one cycle
      if (reg_wr) begin
         errors++;
         $display("FAIL R11 actual reg_wr 1, expected 0");
      end
      bus_wr(8'h00, 8'h12);
      expect_item(0, 'h00, 'h1234, "R2");
      bus_wr(8'h01, 8'h34);
      bus_wr(8'h7E, 8'hFF);
      expect_item(0, 'h3F, 'hFF00, "R2");
      bus_wr(8'h7F, 8'h00);
      drained("R2");

      // R3: orphan or mismatched lower bytes
      cur_req = "R3";
      bus_wr(8'h11, 8'h55);
      bus_wr(8'h20, 8'h11);
      bus_wr(8'h22, 8'h22);
      bus_wr(8'h21, 8'h33);
      drained("R3");
      bus_wr(8'h22, 8'h22);
      expect_item(0, 'h11, 'h2244, "R3");
      bus_wr(8'h23, 8'h44);
      drained("R3");
      bus_wr(8'h23, 8'h66);
      drained("R3");

      // R4: parameterless commands
      cur_req = "R4";
      expect_item(1, 'h43, 0, "R4");
      bus_wr(8'h86, 8'h00);
      bus_wr(8'h86, 8'h01);
      bus_wr(8'h87, 8'h00);
      drained("R4");

      // R5: word reads in any order
      cur_req = "R5";
      expect_item(4, 0, int'(model(7'h08) & 16'h00FF), "R5");
      bus_rd(8'h11);
      expect_item(4, 0, int'(model(7'h08) >> 8), "R5");
      bus_rd(8'h10);
      expect_item(4, 0, int'(model(7'h18) & 16'h00FF), "R5");
      bus_rd(8'h31);
      drained("R5");

      // R6: status bytes
      cur_req = "R6";
      expect_item(4, 0, 'hEF, "R6");
      bus_rd(8'hFF);
      expect_item(4, 0, 'hBE, "R6");
      bus_rd(8'hFE);
      drained("R6");

      // R10: port idle before any image command
      cur_req = "R10";
      bus_wr(8'hFD, 8'h11);
      bus_wr(8'hFD, 8'h22);
      expect_item(4, 0, 'h00, "R10");
      bus_rd(8'hFD);
      drained("R10");

      // R7: pixel writes
      cur_req = "R7";
      expect_item(1, 'h41, 0, "R7");
      bus_wr(8'h82, 8'h00);
      bus_wr(8'hFD, 8'h12);
      expect_item(2, 0, 'h1234, "R7");
      bus_wr(8'hFD, 8'h34);
      bus_wr(8'hFD, 8'h56);
      expect_item(2, 0, 'h5678, "R7");
      bus_wr(8'hFD, 8'h78);
      drained("R7");

      // R9: new command restarts the phase
      cur_req = "R9";
      bus_wr(8'hFD, 8'h99);
      expect_item(1, 'h41, 0, "R9");
      bus_wr(8'h82, 8'h00);
      bus_wr(8'hFD, 8'hAA);
      expect_item(2, 0, 'hAABB, "R9");
      bus_wr(8'hFD, 8'hBB);
      drained("R9");

      // R8: pixel readback
      cur_req = "R8";
      expect_item(1, 'h43, 0, "R8");
      bus_wr(8'h86, 8'h00);
      expect_item(1, 'h42, 0, "R8");
      bus_wr(8'h84, 8'h00);
      expect_item(4, 0, 'h30, "R8");
      bus_rd(8'hFD);
      glitch = 16'hFFFF;
      expect_item(3, 0, 0, "R8");
      expect_item(4, 0, 'h90, "R8");
      bus_rd(8'hFD);
      glitch = 16'h0000;
      expect_item(4, 0, 'h31, "R8");
      bus_rd(8'hFD);
      expect_item(3, 0, 0, "R8");
      expect_item(4, 0, 'h91, "R8");
      bus_rd(8'hFD);
      drained("R8");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule